// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a real address by walking a hashed page table that lives in external memory. Sixteen segment registers, written through an index/data port, supply a virtual segment identifier and two protection keys. From the segment identifier, the page index and a table base/mask input the walker forms the address of a page-table group. It then reads the group's eight tag/data pairs one word at a time and compares each tag word with the expected tag. It searches the primary group first and the secondary group second.

When a tag matches, the walker forms the real address and decodes the read and write permissions from a three-bit protection code. It then writes the referenced and changed flags back into the entry with single-byte writes. One cycle with `done` high reports one of three outcomes: a hit, a permission fault, or a miss.

The controller has eight states. IDLE accepts a request. TAG_REQ issues a tag-word read and TAG_WAIT takes its data. PTE_REQ and PTE_WAIT do the same for the data word of the matching pair. REF_WR writes the referenced byte and CHG_WR writes the changed byte. REPORT raises `done`. The transitions are:
- IDLE→TAG_REQ when a request arrives.
- TAG_REQ→TAG_WAIT when memory accepts the read.
- TAG_WAIT→PTE_REQ on a tag match.
- TAG_WAIT→TAG_REQ on a mismatch while pairs remain, or when the primary group is exhausted and the secondary search begins.
- TAG_WAIT→REPORT on a mismatch at the last pair of the secondary group.
- PTE_REQ→PTE_WAIT when memory accepts the read.
- PTE_WAIT→REF_WR when the data word arrives.
- REF_WR→CHG_WR when no referenced write is needed or the write is accepted.
- CHG_WR→REPORT when no changed write is needed or the write is accepted.
- REPORT→IDLE unconditionally.

Top module: `hpt_walker`

## Requirements
- R1: `req_ready` is high only in IDLE. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low until the walk reports. The segment register used is the one indexed by effective-address bits 31:28, as last written through `seg_we`/`seg_idx`/`seg_wdata`.
- R2: The primary hash is (segment bits 27:0 XOR effective-address bits 27:12) shifted left by 6 and truncated to 32 bits. The group address is `tbl_base` bits 31:16 in the upper half, ORed with the hash ANDed with ({`tbl_base` bits 8:0} shifted left 16, ORed with 0xFFC0).
- R3: Pair i of a group starts at group address + 8·i; its tag word is at +0 and its data word at +4. Pairs are read in ascending order. The expected tag is bit 31 set, ORed with segment bits 27:0 shifted left 7, ORed with effective-address bits 27:22 in bits 5:0. The search stops at the first matching pair.
- R4: If no pair of the primary group matches, the secondary group is searched. Its hash is the bitwise inverse of the primary hash before masking, and its tag also has bit 6 set. A miss in both groups ends with `done` high and both `hit` and `perm_fault` low.
- R5: On a match, `real_addr` is the data word with bits 11:0 replaced by effective-address bits 11:0.
- R6: The protection code is {key, data bits 1:0}. The key is segment bit 29 for a user access and segment bit 30 otherwise. Codes 0, 1, 2 and 6 allow read and write. Codes 3, 5 and 7 allow read only. Code 4 allows nothing.
- R7: A readable match whose data word has bit 8 clear gets a byte write to data-word address + 2 of data bits 15:8 with bit 0 of the byte set. Byte offsets are big-endian: offset 2 holds bits 15:8 and offset 3 holds bits 7:0.
- R8: A permitted write whose data word has bit 7 clear gets a byte write to data-word address + 3 of data bits 7:0 with bit 7 of the byte set. No byte write happens in any other case.
- R9: A match that lacks read permission, or lacks write permission on a write access, ends with `perm_fault` high and `hit` low. `hit` and `perm_fault` are never high together.
- R10: `done` is high for exactly one cycle per request. A memory request stays valid with its address and command unchanged until `mem_req_ready` accepts it. Each accepted read is answered by exactly one `mem_rsp_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_idx | input | 4 | Segment register index to write |
| seg_wdata | input | 32 | Segment register write value |
| tbl_base | input | 32 | Table base (bits 31:16) and hash mask extension (bits 8:0) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| done | output | 1 | One-cycle completion strobe |
| hit | output | 1 | Translation succeeded with permission |
| perm_fault | output | 1 | Entry found but access not permitted |
| real_addr | output | 32 | Translated address, valid with hit or perm_fault |
| mem_req_valid | output | 1 | Memory command valid |
| mem_req_ready | input | 1 | Memory command accepted |
| mem_req_write | output | 1 | 0: word read, 1: byte write |
| mem_req_addr | output | 32 | Byte address of the command |
| mem_req_byte | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The properties assume that memory answers each accepted read exactly once, never before it is accepted, and never sends an unsolicited response. They also assume that `tbl_base` and the segment register in use stay constant while a walk is in progress. The stimulus meets these assumptions in three ways. The memory model replies on the cycle after it accepts a read. Segment registers and `tbl_base` change only while the walker is idle. Back-pressure comes from a periodic stall on `mem_req_ready` that never drops a command.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

    localparam int EA_W       = 32;
    localparam int SEG_CNT    = 16;
    localparam int SEG_IDX_W  = $clog2(SEG_CNT);
    localparam int VSID_W     = 28;
    localparam int PAGE_W     = 16;
    localparam int OFS_W      = 12;
    localparam int WORD_BYTES = 4;
    localparam int MASK_LO_W  = 9;
    localparam int BASE_HI_W  = 16;
    localparam int REF_BIT    = 8;
    localparam int CHG_BIT    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG_REQ,
        ST_TAG_WAIT,
        ST_PTE_REQ,
        ST_PTE_WAIT,
        ST_REF_WR,
        ST_CHG_WR,
        ST_REPORT
    } walk_state_e;

endpackage

// File: rtl/hptw_segfile.sv
module hptw_segfile
    import hptw_pkg::*;
#(
    parameter int N_REGS = SEG_CNT,
    parameter int REG_W  = EA_W,
    localparam int IDX_W = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_data
);

    logic [REG_W-1:0] regs [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/hptw_hash.sv
module hptw_hash
    import hptw_pkg::*;
(
    input  logic [VSID_W-1:0]    vsid,
    input  logic [PAGE_W-1:0]    page,
    input  logic [BASE_HI_W-1:0] base_hi,
    input  logic [MASK_LO_W-1:0] mask_lo,
    input  logic                 secondary,
    output logic [EA_W-1:0]      grp_addr,
    output logic [EA_W-1:0]      tag
);

    logic [EA_W-1:0] mixed;
    logic [EA_W-1:0] hashed;
    logic [EA_W-1:0] mask;

    always_comb begin
        mixed  = EA_W'(vsid) ^ EA_W'(page);
        hashed = mixed << 6;
        if (secondary) begin
            hashed = ~hashed;
        end
        mask     = {7'b0, mask_lo, 16'hFFC0};
        grp_addr = {base_hi, 16'h0000} | (hashed & mask);
        tag      = 32'h8000_0000
                 | (EA_W'(vsid) << 7)
                 | (secondary ? 32'h0000_0040 : 32'h0)
                 | EA_W'(page[PAGE_W-1:PAGE_W-6]);
    end

endmodule

// File: rtl/hptw_perm.sv
module hptw_perm (
    input  logic       sup_key,
    input  logic       usr_key,
    input  logic       user,
    input  logic [1:0] pp,
    output logic       may_read,
    output logic       may_write
);

    logic [2:0] code;

    always_comb begin
        code = {(user ? usr_key : sup_key), pp};
        unique case (code)
            3'd0, 3'd1, 3'd2, 3'd6: begin
                may_read  = 1'b1;
                may_write = 1'b1;
            end
            3'd3, 3'd5, 3'd7: begin
                may_read  = 1'b1;
                may_write = 1'b0;
            end
            3'd4: begin
                may_read  = 1'b0;
                may_write = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hptw_pkg::*;
#(
    parameter int PAIRS = 8,
    localparam int PAIR_W = $clog2(PAIRS),
    localparam int PAIR_STRIDE_SH = $clog2(2 * WORD_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seg_we,
    input  logic [SEG_IDX_W-1:0] seg_idx,
    input  logic [EA_W-1:0]      seg_wdata,
    input  logic [EA_W-1:0]      tbl_base,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [EA_W-1:0]      req_ea,
    input  logic                 req_write,
    input  logic                 req_user,
    output logic                 done,
    output logic                 hit,
    output logic                 perm_fault,
    output logic [EA_W-1:0]      real_addr,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_write,
    output logic [EA_W-1:0]      mem_req_addr,
    output logic [7:0]           mem_req_byte,
    input  logic                 mem_rsp_valid,
    input  logic [EA_W-1:0]      mem_rsp_data
);

    walk_state_e state_q, state_d;

    logic [EA_W-1:0]   seg_rd;
    logic [EA_W-1:0]   sr_q;
    logic [27:0]       ea_q;
    logic              wr_q;
    logic              usr_q;
    logic              sec_q;
    logic [PAIR_W-1:0] pair_q;
    logic [15:0]       pte_q;
    logic              hit_q;
    logic              fault_q;
    logic [EA_W-1:0]   raddr_q;

    logic [EA_W-1:0]   grp_addr;
    logic [EA_W-1:0]   tag_exp;
    logic [EA_W-1:0]   pair_addr;
    logic              may_read;
    logic              may_write;
    logic              need_ref;
    logic              need_chg;
    logic              tag_match;
    logic              last_pair;
    logic              access_ok;
    logic              unused_bits;

    assign unused_bits = ^{tbl_base[15:9], sr_q[31]};

    hptw_segfile #(
        .N_REGS (SEG_CNT),
        .REG_W  (EA_W)
    ) u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_we),
        .wr_idx  (seg_idx),
        .wr_data (seg_wdata),
        .rd_idx  (req_ea[EA_W-1:EA_W-SEG_IDX_W]),
        .rd_data (seg_rd)
    );

    hptw_hash u_hash (
        .vsid      (sr_q[VSID_W-1:0]),
        .page      (ea_q[27:OFS_W]),
        .base_hi   (tbl_base[EA_W-1:EA_W-BASE_HI_W]),
        .mask_lo   (tbl_base[MASK_LO_W-1:0]),
        .secondary (sec_q),
        .grp_addr  (grp_addr),
        .tag       (tag_exp)
    );

    hptw_perm u_perm (
        .sup_key   (sr_q[30]),
        .usr_key   (sr_q[29]),
        .user      (usr_q),
        .pp        (pte_q[1:0]),
        .may_read  (may_read),
        .may_write (may_write)
    );

    assign pair_addr = grp_addr | (EA_W'(pair_q) << PAIR_STRIDE_SH);
    assign tag_match = (mem_rsp_data == tag_exp);
    assign last_pair = (pair_q == PAIR_W'(PAIRS - 1));
    assign need_ref  = may_read && !pte_q[REF_BIT];
    assign need_chg  = wr_q && may_write && !pte_q[CHG_BIT];
    assign access_ok = may_read && (!wr_q || may_write);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_TAG_REQ;
            ST_TAG_REQ:  if (mem_req_ready) state_d = ST_TAG_WAIT;
            ST_TAG_WAIT: begin
                if (mem_rsp_valid) begin
                    if (tag_match)              state_d = ST_PTE_REQ;
                    else if (last_pair && sec_q) state_d = ST_REPORT;
                    else                         state_d = ST_TAG_REQ;
                end
            end
            ST_PTE_REQ:  if (mem_req_ready) state_d = ST_PTE_WAIT;
            ST_PTE_WAIT: if (mem_rsp_valid) state_d = ST_REF_WR;
            ST_REF_WR:   if (!need_ref || mem_req_ready) state_d = ST_CHG_WR;
            ST_CHG_WR:   if (!need_chg || mem_req_ready) state_d = ST_REPORT;
            ST_REPORT:   state_d = ST_IDLE;
        endcase
    end

    // walk context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            ea_q    <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            sec_q   <= 1'b0;
            pair_q  <= '0;
            pte_q   <= '0;
            hit_q   <= 1'b0;
            fault_q <= 1'b0;
            raddr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        sr_q    <= seg_rd;
                        ea_q    <= req_ea[27:0];
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        sec_q   <= 1'b0;
                        pair_q  <= '0;
                        hit_q   <= 1'b0;
                        fault_q <= 1'b0;
                    end
                end
                ST_TAG_WAIT: begin
                    if (mem_rsp_valid && !tag_match) begin
                        if (last_pair) begin
                            sec_q  <= 1'b1;
                            pair_q <= '0;
                        end else begin
                            pair_q <= pair_q + PAIR_W'(1);
                        end
                    end
                end
                ST_PTE_WAIT: begin
                    if (mem_rsp_valid) begin
                        pte_q   <= mem_rsp_data[15:0];
                        raddr_q <= {mem_rsp_data[EA_W-1:OFS_W], ea_q[OFS_W-1:0]};
                    end
                end
                ST_REF_WR: begin
                    if (need_ref && mem_req_ready) begin
                        pte_q[REF_BIT] <= 1'b1;
                    end
                end
                ST_CHG_WR: begin
                    if (!need_chg || mem_req_ready) begin
                        hit_q   <= access_ok;
                        fault_q <= !access_ok;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        done          = (state_q == ST_REPORT);
        hit           = hit_q;
        perm_fault    = fault_q;
        real_addr     = raddr_q;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = pair_addr;
        mem_req_byte  = '0;
        unique case (state_q)
            ST_TAG_REQ: begin
                mem_req_valid = 1'b1;
            end
            ST_PTE_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = pair_addr | EA_W'(WORD_BYTES);
            end
            ST_REF_WR: begin
                mem_req_valid = need_ref;
                mem_req_write = 1'b1;
                mem_req_addr  = pair_addr | EA_W'(WORD_BYTES + 2);
                mem_req_byte  = {pte_q[15:9], 1'b1};
            end
            ST_CHG_WR: begin
                mem_req_valid = need_chg;
                mem_req_write = 1'b1;
                mem_req_addr  = pair_addr | EA_W'(WORD_BYTES + 3);
                mem_req_byte  = {1'b1, pte_q[6:0]};
            end
            default: ;
        endcase
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R1

    AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write |-> mem_req_addr[1:0] == 2'b00); // R3

    AST_REF_BYTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write && (mem_req_addr[1:0] == 2'd2) |-> mem_req_byte[0]); // R7

    AST_CHG_BYTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write && (mem_req_addr[1:0] == 2'd3) |-> mem_req_byte[7]); // R8

    AST_WRITE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_addr[1]); // R8

    AST_NO_HIT_AND_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(hit && perm_fault)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_byte)); // R10

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready); // R1

endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NVEC       = 9;

    typedef struct packed {
        logic [31:0] ea;
        logic        wr;
        logic        usr;
        logic [31:0] sr;
        logic [31:0] lo;
        logic [1:0]  where;   // 0 none, 1 primary, 2 secondary
        logic [2:0]  slot;
        logic        exp_hit;
        logic        exp_fault;
        logic [31:0] exp_lo;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h1234_5678, 1'b0, 1'b0, 32'h0000_1234, 32'h0ABC_D002, 2'd1, 3'd0, 1'b1, 1'b0, 32'h0ABC_D102},
        '{32'h3000_1ABC, 1'b1, 1'b0, 32'h0ABC_DEF0, 32'h0005_5000, 2'd1, 3'd5, 1'b1, 1'b0, 32'h0005_5180},
        '{32'h5555_5555, 1'b0, 1'b1, 32'h2000_0055, 32'h0006_6000, 2'd1, 3'd2, 1'b0, 1'b1, 32'h0006_6000},
        '{32'h7ABC_D123, 1'b1, 1'b1, 32'h2123_4567, 32'h0007_7003, 2'd2, 3'd1, 1'b0, 1'b1, 32'h0007_7103},
        '{32'h9FFF_FFFC, 1'b1, 1'b0, 32'h4765_4321, 32'h0008_8102, 2'd2, 3'd7, 1'b1, 1'b0, 32'h0008_8182},
        '{32'hB012_3456, 1'b0, 1'b0, 32'h0111_1111, 32'h0000_0000, 2'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000},
        '{32'hD0F0_0F0F, 1'b0, 1'b1, 32'h4000_0F0F, 32'h0009_9181, 2'd2, 3'd2, 1'b1, 1'b0, 32'h0009_9181},
        '{32'hF765_4321, 1'b0, 1'b0, 32'h4FED_CBA9, 32'h000A_A001, 2'd1, 3'd7, 1'b1, 1'b0, 32'h000A_A101},
        '{32'h2468_ACE0, 1'b1, 1'b1, 32'h6AAA_AAAA, 32'h000B_B002, 2'd1, 3'd3, 1'b1, 1'b0, 32'h000B_B182}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_idx = '0;
    logic [31:0] seg_wdata = '0;
    logic [31:0] tbl_base = 32'h0012_0003;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_ea = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        done, hit, perm_fault;
    logic [31:0] real_addr;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic [7:0]  mem_req_byte;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    logic [31:0] mem [logic [31:0]];
    int          wr_cnt = 0;
    int          cyc = 0;
    int          checks = 0;
    int          failures = 0;

    hpt_walker uut (
        .clk (clk), .rst_n (rst_n),
        .seg_we (seg_we), .seg_idx (seg_idx), .seg_wdata (seg_wdata),
        .tbl_base (tbl_base),
        .req_valid (req_valid), .req_ready (req_ready), .req_ea (req_ea),
        .req_write (req_write), .req_user (req_user),
        .done (done), .hit (hit), .perm_fault (perm_fault), .real_addr (real_addr),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write), .mem_req_addr (mem_req_addr),
        .mem_req_byte (mem_req_byte),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: reply one cycle after accepting a read, big-endian bytes
    always @(posedge clk) begin
        logic [31:0] wa, cur;
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            wa  = {mem_req_addr[31:2], 2'b00};
            cur = mem.exists(wa) ? mem[wa] : 32'h0;
            if (mem_req_write) begin
                case (mem_req_addr[1:0])
                    2'd0: cur[31:24] = mem_req_byte;
                    2'd1: cur[23:16] = mem_req_byte;
                    2'd2: cur[15:8]  = mem_req_byte;
                    2'd3: cur[7:0]   = mem_req_byte;
                endcase
                mem[wa] = cur;
                wr_cnt  = wr_cnt + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= cur;
            end
        end
    end

    always @(negedge clk) mem_req_ready <= ((cyc % 4) != 3);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] grp_of(input logic [31:0] sr, input logic [31:0] ea,
                                           input logic [31:0] tb, input bit sec);
        logic [31:0] h;
        h = ({4'b0, sr[27:0]} ^ {16'b0, ea[27:12]}) << 6;
        if (sec) h = ~h;
        return {tb[31:16], 16'h0} | (h & ({7'b0, tb[8:0], 16'h0} | 32'h0000_FFC0));
    endfunction

    function automatic logic [31:0] tag_of(input logic [31:0] sr, input logic [31:0] ea, input bit sec);
        return 32'h8000_0000 | ({4'b0, sr[27:0]} << 7) | (sec ? 32'h40 : 32'h0) | {26'b0, ea[27:22]};
    endfunction

    task automatic run_vec(input vec_t v, input string lbl);
        logic [31:0] gp, gs, tp, ts, entry;
        int base_wr, t, exp_wr;
        gp = grp_of(v.sr, v.ea, tbl_base, 1'b0);
        gs = grp_of(v.sr, v.ea, tbl_base, 1'b1);
        tp = tag_of(v.sr, v.ea, 1'b0);
        ts = tag_of(v.sr, v.ea, 1'b1);
        mem.delete();
        entry = 32'h0;
        if (v.where == 2'd1) begin
            for (int s = 0; s < int'(v.slot); s++) mem[gp + 32'(8*s)] = tp ^ 32'h1;
            mem[gp + 32'(8*v.slot)] = tp;
            mem[gp + 32'(8*v.slot) + 4] = v.lo;
            if (v.slot != 3'd7) begin
                mem[gp + 32'(8*v.slot) + 8]  = tp;
                mem[gp + 32'(8*v.slot) + 12] = 32'hDEAD_0000 | (v.lo & 32'h3);
            end
            entry = gp + 32'(8*v.slot) + 4;
        end else if (v.where == 2'd2) begin
            for (int s = 0; s < 8; s++) mem[gp + 32'(8*s)] = tp ^ 32'h1;
            mem[gs + 32'(8*v.slot)] = ts;
            mem[gs + 32'(8*v.slot) + 4] = v.lo;
            entry = gs + 32'(8*v.slot) + 4;
        end
        // program a neighbouring segment with other data, then the selected one
        @(negedge clk);
        seg_we = 1'b1; seg_idx = v.ea[31:28] ^ 4'h1; seg_wdata = ~v.sr;
        @(negedge clk);
        seg_idx = v.ea[31:28]; seg_wdata = v.sr;
        @(negedge clk);
        seg_we = 1'b0;
        base_wr = wr_cnt;
        req_valid = 1'b1; req_ea = v.ea; req_write = v.wr; req_user = v.usr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {"R1 ready low while busy ", lbl}, 32'(req_ready), 32'h0);
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, {"R10 done reached ", lbl}, 32'(done), 32'h1);
        if (v.where == 2'd0) begin
            chk(hit == 1'b0 && perm_fault == 1'b0, {"R4 miss in both groups ", lbl},
                {30'b0, hit, perm_fault}, 32'h0);
        end else begin
            chk(hit == v.exp_hit, {(v.where == 2'd2) ? "R4 secondary hit " : "R6 hit ", lbl},
                32'(hit), 32'(v.exp_hit));
            chk(perm_fault == v.exp_fault, {"R9 perm_fault ", lbl}, 32'(perm_fault), 32'(v.exp_fault));
            chk(real_addr == {v.lo[31:12], v.ea[11:0]},
                {(v.where == 2'd1) ? "R3 first match R5 real_addr " : "R5 real_addr ", lbl},
                real_addr, {v.lo[31:12], v.ea[11:0]});
            chk(mem[entry] == v.exp_lo, {"R7 R8 entry flags ", lbl}, mem[entry], v.exp_lo);
        end
        exp_wr = int'((v.exp_lo[8] ^ v.lo[8])) + int'((v.exp_lo[7] ^ v.lo[7]));
        chk(wr_cnt - base_wr == exp_wr, {"R8 byte write count ", lbl}, 32'(wr_cnt - base_wr), 32'(exp_wr));
        @(negedge clk);
        chk(done == 1'b0, {"R10 done one cycle ", lbl}, 32'(done), 32'h0);
        chk(req_ready == 1'b1, {"R1 idle after report ", lbl}, 32'(req_ready), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R10 reset done low", 32'(done), 32'h0);
        chk(req_ready == 1'b1, "R1 reset ready high", 32'(req_ready), 32'h1);
        chk(mem_req_valid == 1'b0, "R10 reset no memory command", 32'(mem_req_valid), 32'h0);
        chk(hit == 1'b0 && perm_fault == 1'b0, "R9 reset outcome clear", {30'b0, hit, perm_fault}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], $sformatf("vec%0d", i));
        end

        // R2: wider mask and another base change the group location
        tbl_base = 32'h0040_01FF;
        run_vec(VECS[0], "R2 mask ext primary");
        run_vec(VECS[4], "R2 mask ext secondary");
        tbl_base = 32'hFFFF_0000;
        run_vec(VECS[7], "R2 zero mask ext");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule